// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a clocked single-port static RAM for a cache data path. It holds words of two 9-bit halves, 18 bits in all. Every input except the output enable is captured in a register at the rising clock edge. The access that these registers hold is performed on the next edge, and that edge also loads an output register. Read data therefore appears one clock after the access is registered. The full-size part holds 65,536 words behind a 16-bit address. For simulation the array depth is set by a parameter, and the address bits above that depth are not used.

A burst of four words starts from an external address. Either of two address-status strobes can start it: one from the processor and one from the cache controller. The processor strobe counts only while chip enable is high, so a processor can place its next address on the bus early. The controller strobe counts regardless of chip enable. After the start, an internal two-bit counter supplies the rest of the burst. The counter steps only when the advance input is high. Each word address is the start address with its two low bits XORed with the count, which gives the interleaved line-fill order and keeps the burst inside its aligned group of four words.

Two lane write enables select the lower and upper halves of the word. A write needs only the clock edge, with no shaped write pulse. The data output is a tri-state bus whose enable acts without waiting for the clock.

Top module: `burst_sram`

## Requirements
- R1: While synchronous active-low reset is applied, the output register holds zero, so `dq` reads 0 with `oe` high. Reset also clears the burst state to address 0 with count 0.
- R2: Inputs sampled at edge n select an access. The word read by that access is on `dq` after edge n+1. On a write access, `dq` shows the word as it was before the write.
- R3: `ads_c` high at an edge loads the burst start from `addr` and clears the count, whatever the level of `ce`. A write enabled on that cycle goes to the start address.
- R4: `ads_p` loads the burst start only when `ce` is high. With `ce` low, `ads_p` has no effect: the address is held, or advanced, or loaded by `ads_c`.
- R5: An access started by an enabled `ads_p` is read-only, and both lane write enables are ignored. When `ads_p` (with `ce` high) and `ads_c` arrive on the same edge, the processor start wins, so the cycle is a read.
- R6: On a cycle with no load and `adv` high, the count steps by one modulo 4. The word address is the start address with bits 1:0 replaced by start[1:0] XOR count. For example, start 6 gives 6, 7, 4, 5, and a fourth step returns to 6.
- R7: On a cycle with no load and `adv` low, the word address repeats. A write on such a cycle goes to that repeated address.
- R8: `we_lo` writes bits 8:0 and `we_hi` writes bits 17:9. Either may be used alone or both together, and a lane whose enable is low keeps its old contents.
- R9: `oe` acts without the clock. With `oe` low, `dq` is high-impedance. With `oe` high, `dq` carries the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable, gates `ads_p` |
| ads_p | input | 1 | Processor burst-start strobe |
| ads_c | input | 1 | Controller burst-start strobe |
| adv | input | 1 | Burst counter advance |
| we_lo | input | 1 | Write enable for bits 8:0 |
| we_hi | input | 1 | Write enable for bits 17:9 |
| oe | input | 1 | Asynchronous output enable |
| addr | input | ADDR_W (16) | Burst start address |
| wdata | input | 2*LANE_W (18) | Write data |
| dq | output | 2*LANE_W (18) | Tri-state read data |

## Verification
Both start strobes can arrive on the same edge, and that edge can carry a write. The scoreboard raises `ads_p` and `ads_c` together with `ce` high and both write enables set, and it expects a read. A following hold cycle must show that the word is unchanged. The bench then repeats the collision with `ce` low. This time the controller strobe must load the address and the write must land, so the write cycle shows the old word and the next cycle shows the new one.

// File: rtl/burst_sram_pkg.sv
// Package: shared types for the pipelined burst SRAM.
// Assumes a word made of exactly two byte lanes, lower and upper.
package burst_sram_pkg;

    localparam int LANES = 2;   // lower half, upper half
    localparam int CNT_W = 2;   // four-beat burst

    // Registered control inputs of one clock cycle.
    typedef struct packed {
        logic             ce;
        logic             ads_p;
        logic             ads_c;
        logic             adv;
        logic [LANES-1:0] we;     // bit 0 lower lane, bit 1 upper lane
    } ctl_s;

    // What the burst logic does with the registered controls.
    typedef enum logic [1:0] {
        ACC_HOLD      = 2'd0,
        ACC_STEP      = 2'd1,
        ACC_LOAD_PROC = 2'd2,
        ACC_LOAD_CTRL = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/sram_in_reg.sv
// Module: input register stage.
// Captures controls, address and write data at each rising edge.
// Assumes a synchronous active-low reset that clears every control to idle.
module sram_in_reg
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_s              ctl_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] wdata_d,
    output ctl_s              ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Control register: reset puts every strobe and enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Address and data register: reset clears them for a known start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst address generator.
// Decodes the registered strobes and produces the word address and lane
// write mask for the access in progress.
// An enabled processor strobe wins over the controller strobe, and the
// access it starts is read-only. The count runs modulo 4 and is XORed into
// the two low address bits.
// Assumes DEPTH_W > CNT_W.
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int DEPTH_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctl_s               ctl_q,
    input  logic [DEPTH_W-1:0] start_addr,
    output logic [DEPTH_W-1:0] acc_addr,
    output logic [LANES-1:0]   lane_we,
    output logic [DEPTH_W-1:0] burst_base,
    output logic [CNT_W-1:0]   burst_cnt
);

    localparam int HI_W = DEPTH_W - CNT_W;

    acc_kind_e          kind;
    logic               proc_ld;
    logic               ctrl_ld;
    logic [DEPTH_W-1:0] base_n;
    logic [CNT_W-1:0]   cnt_n;

    // Strobe decode: the processor strobe counts only with chip enable.
    always_comb begin
        proc_ld = ctl_q.ads_p & ctl_q.ce;
        ctrl_ld = ctl_q.ads_c & ~proc_ld;
        if (proc_ld) begin
            kind = ACC_LOAD_PROC;
        end else if (ctrl_ld) begin
            kind = ACC_LOAD_CTRL;
        end else if (ctl_q.adv) begin
            kind = ACC_STEP;
        end else begin
            kind = ACC_HOLD;
        end
    end

    // Next burst state: load a new start, step the count, or hold.
    always_comb begin
        base_n = burst_base;
        cnt_n  = burst_cnt;
        unique case (kind)
            ACC_LOAD_PROC, ACC_LOAD_CTRL: begin
                base_n = start_addr;
                cnt_n  = '0;
            end
            ACC_STEP: begin
                cnt_n = burst_cnt + CNT_W'(1);
            end
            default: begin
                cnt_n = burst_cnt;
            end
        endcase
    end

    // Word address: interleaved order inside the aligned group of four.
    always_comb begin
        acc_addr = {base_n[DEPTH_W-1 -: HI_W], base_n[CNT_W-1:0] ^ cnt_n};
    end

    // Lane write mask: a processor-started access never writes.
    always_comb begin
        lane_we = (kind == ACC_LOAD_PROC) ? '0 : ctl_q.we;
    end

    // Burst state register: start address and beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_base <= '0;
            burst_cnt  <= '0;
        end else begin
            burst_base <= base_n;
            burst_cnt  <= cnt_n;
        end
    end

endmodule

// File: rtl/sram_lane_array.sv
// Module: byte-lane storage array with a registered read port.
// Each lane is a separate memory with its own write enable. The read
// register takes the word as it was before any write on the same edge.
// Assumes the array contents are not reset. Only the read register is.
module sram_lane_array
    import burst_sram_pkg::*;
#(
    parameter int DEPTH_W = 10,
    parameter int LANE_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH_W-1:0]      acc_addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dout_q
);

    localparam int DEPTH = 1 << DEPTH_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write: the clock edge alone completes the write.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Lane read register: cleared by reset, otherwise the old word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dout_q[g*LANE_W +: LANE_W] <= '0;
            end else begin
                dout_q[g*LANE_W +: LANE_W] <= mem[acc_addr];
            end
        end
    end

endmodule

// File: rtl/burst_sram.sv
// Module: pipelined synchronous burst SRAM, top level.
// Inputs are registered. The registered access is performed on the next
// edge, and that edge also loads the output register. The tri-state output
// enable acts without the clock.
// Assumes DEPTH_W <= ADDR_W. Address bits above DEPTH_W are not used.
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DEPTH_W = 10,
    parameter int LANE_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic                    ads_p,
    input  logic                    ads_c,
    input  logic                    adv,
    input  logic                    we_lo,
    input  logic                    we_hi,
    input  logic                    oe,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dq
);

    localparam int DATA_W = LANES * LANE_W;

    ctl_s               ctl_d;
    ctl_s               ctl_q;
    logic [DEPTH_W-1:0] addr_d;
    logic [DEPTH_W-1:0] addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DEPTH_W-1:0] acc_addr;
    logic [LANES-1:0]   lane_we;
    logic [DEPTH_W-1:0] burst_base;
    logic [CNT_W-1:0]   burst_cnt;
    logic [DATA_W-1:0]  dout_q;

    // Control bundle: collects the clocked control pins.
    always_comb begin
        ctl_d.ce    = ce;
        ctl_d.ads_p = ads_p;
        ctl_d.ads_c = ads_c;
        ctl_d.adv   = adv;
        ctl_d.we    = {we_hi, we_lo};
    end

    // Address trim: keep the bits the array decodes.
    assign addr_d = addr[DEPTH_W-1:0];

    if (DEPTH_W < ADDR_W) begin : g_addr_trim
        logic unused_addr_hi;
        assign unused_addr_hi = ^addr[ADDR_W-1:DEPTH_W];
    end

    sram_in_reg #(
        .ADDR_W (DEPTH_W),
        .DATA_W (DATA_W)
    ) u_in_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_d   (ctl_d),
        .addr_d  (addr_d),
        .wdata_d (wdata),
        .ctl_q   (ctl_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    burst_addr_gen #(
        .DEPTH_W (DEPTH_W)
    ) u_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_q      (ctl_q),
        .start_addr (addr_q),
        .acc_addr   (acc_addr),
        .lane_we    (lane_we),
        .burst_base (burst_base),
        .burst_cnt  (burst_cnt)
    );

    sram_lane_array #(
        .DEPTH_W (DEPTH_W),
        .LANE_W  (LANE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (acc_addr),
        .lane_we  (lane_we),
        .wdata    (wdata_q),
        .dout_q   (dout_q)
    );

    // Output driver: asynchronous enable onto the tri-state bus.
    assign dq = oe ? dout_q : {DATA_W{1'bz}};

endmodule

// File: rtl/burst_sram_chk.sv
// Module: protocol checker for burst_sram, attached with bind.
// Watches the registered strobes, the burst state and the output register.
module burst_sram_chk #(
    parameter int DEPTH_W = 10,
    parameter int DATA_W  = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ce_q,
    input logic               adsp_q,
    input logic               adsc_q,
    input logic               adv_q,
    input logic [1:0]         lane_we,
    input logic [DEPTH_W-1:0] burst_base,
    input logic [1:0]         burst_cnt,
    input logic [DATA_W-1:0]  dout_q
);

    logic p_ld;
    logic any_ld;
    assign p_ld   = adsp_q & ce_q;
    assign any_ld = p_ld | adsc_q;

    AST_RESET_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout_q == '0)); // R1

    AST_CTRL_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        adsc_q |=> (burst_cnt == 2'd0)); // R3

    AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_q && !ce_q && !adsc_q && !adv_q) |=> ($stable(burst_cnt) && $stable(burst_base))); // R4

    AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        p_ld |-> (lane_we == 2'b00)); // R5

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_q && !any_ld) |=> ((burst_cnt == $past(burst_cnt) + 2'd1) && $stable(burst_base))); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_q && !any_ld) |=> ($stable(burst_cnt) && $stable(burst_base))); // R7

endmodule

bind burst_sram burst_sram_chk #(
    .DEPTH_W (DEPTH_W),
    .DATA_W  (LANES * LANE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_q       (ctl_q.ce),
    .adsp_q     (ctl_q.ads_p),
    .adsc_q     (ctl_q.ads_c),
    .adv_q      (ctl_q.adv),
    .lane_we    (lane_we),
    .burst_base (burst_base),
    .burst_cnt  (burst_cnt),
    .dout_q     (dout_q)
);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
// Bench: scoreboard for burst_sram. A driver task models each cycle and
// queues the expected word. A monitor compares dq two edges later.
module test_burst_sram;

    localparam int ADDR_W  = 16;
    localparam int DEPTH_W = 10;
    localparam int LANE_W  = 9;
    localparam int DATA_W  = 2 * LANE_W;
    localparam int DEPTH   = 1 << DEPTH_W;

    typedef struct {
        int               due;
        logic [DATA_W-1:0] exp;
        bit               chk;
        string            req;
    } item_s;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce = 1'b0, ads_p = 1'b0, ads_c = 1'b0, adv = 1'b0;
    logic              we_lo = 1'b0, we_hi = 1'b0, oe = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    wire  [DATA_W-1:0] dq_bus;

    int total = 0;
    int bad   = 0;
    int ncyc  = 0;
    bit done  = 1'b0;

    item_s             sb_q[$];
    logic [DATA_W-1:0] m_mem [DEPTH];
    bit                m_known [DEPTH];
    logic [DEPTH_W-1:0] m_base = '0;
    logic [1:0]         m_cnt  = '0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pu
        pullup pu (dq_bus[i]);
    end

    burst_sram #(
        .ADDR_W  (ADDR_W),
        .DEPTH_W (DEPTH_W),
        .LANE_W  (LANE_W)
    ) i_burst_sram (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .ads_p (ads_p),
        .ads_c (ads_c),
        .adv   (adv),
        .we_lo (we_lo),
        .we_hi (we_hi),
        .oe    (oe),
        .addr  (addr),
        .wdata (wdata),
        .dq    (dq_bus)
    );

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops every item that is due at this falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= ncyc) begin
            item_s it;
            it = sb_q.pop_front();
            if (it.chk) check(it.req, dq_bus, it.exp);
        end
    end

    function automatic logic [DATA_W-1:0] pat(input int a);
        return DATA_W'(32'h15a3c ^ (a * 32'h0251));
    endfunction

    // Driver: one cycle of stimulus plus the reference model of that cycle.
    task automatic step(input bit s_ce, input bit s_p, input bit s_c, input bit s_adv,
                        input bit s_wlo, input bit s_whi, input int s_addr,
                        input logic [DATA_W-1:0] s_wd, input string req);
        bit p_ld;
        int a;
        item_s it;
        @(negedge clk);
        ce = s_ce; ads_p = s_p; ads_c = s_c; adv = s_adv;
        we_lo = s_wlo; we_hi = s_whi;
        addr = ADDR_W'(s_addr); wdata = s_wd;
        p_ld = s_p && s_ce;
        if (p_ld || s_c) begin
            m_base = DEPTH_W'(s_addr);
            m_cnt  = 2'd0;
        end else if (s_adv) begin
            m_cnt = m_cnt + 2'd1;
        end
        a = int'({m_base[DEPTH_W-1:2], m_base[1:0] ^ m_cnt});
        it.due = ncyc + 2;
        it.exp = m_mem[a];
        it.chk = m_known[a];
        it.req = req;
        sb_q.push_back(it);
        if (!p_ld) begin
            if (s_wlo) m_mem[a][LANE_W-1:0] = s_wd[LANE_W-1:0];
            if (s_whi) m_mem[a][DATA_W-1:LANE_W] = s_wd[DATA_W-1:LANE_W];
            if (s_wlo && s_whi) m_known[a] = 1'b1;
        end
    endtask

    task automatic idle(input string req);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, req);
    endtask

    initial begin
        int a0;
        for (int i = 0; i < DEPTH; i++) begin
            m_mem[i]   = '0;
            m_known[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R1 reset output", dq_bus, '0);
        rst_n = 1'b1;

        // Fill 16 words in bursts started by the controller strobe, ce low.
        for (int b = 0; b < 4; b++) begin
            int s;
            s = b * 4 + ((b == 2) ? 1 : 0);
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, s, pat(s), "R3 fill start");
            for (int k = 1; k < 4; k++) begin
                int w;
                w = (s & ~3) | ((s & 3) ^ k);
                step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0, pat(w), "R6 fill step");
            end
        end

        // Processor read burst from 6: 6,7,4,5, then the wrap back to 6.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6, '0, "R2 proc start read");
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, '0, "R6 interleave step");
        // Hold repeats the word.
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, "R7 hold repeat");
        // Processor strobe with ce low is ignored.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12, '0, "R4 gated proc ignored");
        // Burst started at 9 reads 9,8,11,10.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9, '0, "R6 start 9");
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, '0, "R6 order from 9");
        // ce low with both strobes: the controller strobe loads 13.
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13, '0, "R4 ctrl wins when gated");
        // Both strobes with ce high and a write: read only.
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 18'h3ffff, "R5 collision read");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, "R5 word unchanged");
        // Both strobes with ce low and a write: the write lands.
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3, 18'h2a5a5, "R2 write shows old");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, "R3 ctrl write landed");
        // Lane writes: lower only at 5, then upper only on a hold cycle.
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5, 18'h3fe01, "R8 lower write");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, "R8 lower lane only");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 18'h0b1ff, "R7 hold write");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, "R8 upper lane only");
        idle("R7 drain");
        idle("R7 drain");
        while (sb_q.size() > 0) @(negedge clk);

        // Output enable acts between clock edges.
        a0 = int'({m_base[DEPTH_W-1:2], m_base[1:0] ^ m_cnt});
        @(negedge clk);
        #2 oe = 1'b0;
        #1 check("R9 oe low releases bus", dq_bus, {DATA_W{1'b1}});
        oe = 1'b1;
        #1 check("R9 oe high drives word", dq_bus, m_mem[a0]);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule